// File: doc/BRIEF.md
# Direct-interpolation staircase averaging controller

This block is the digital core of a direct-interpolation converter. Once per sampling period it puts an external sample-hold into hold. It then steps a staircase code that drives an interpolation DAC whose output is added to the held value. It gathers one fast-ADC result per staircase step. When the last step has been converted, it presents the sum of those results. The sum is read as an average that carries log2(N) extra fractional bits, where N is the number of steps.

A sampling period is one track cycle, one settle cycle and N tread cycles, all on the conversion clock. The interpolation factor N (2, 4, 8 or 16) and the staircase step size are run-time settings. Both are captured only in the track cycle, so a change takes effect at the next period. The accumulator starts from zero in every period, so each output depends on one held sample only. A period in which any tread lacks a valid ADC code is flagged as missed.

Top module: `di_stair_avg`

## Requirements
- R1: While `rst_n` is low, `sh_hold`, `stair_code`, `res_vld`, `res_miss` and `res_data` are all 0.
- R2: After reset, each period is 1 track cycle (`sh_hold`=0), then 1 settle cycle (`sh_hold`=1), then N tread cycles (`sh_hold`=1), repeating with length N+2.
- R3: In tread k (k = 0 to N-1), `stair_code` equals k times the captured step; it is 0 in the track and settle cycles.
- R4: `cfg_lg` selects N = 2 << `cfg_lg`: the value 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16.
- R5: `cfg_lg` and `cfg_step` are sampled only in the track cycle; values applied in any other cycle do not affect the period in progress.
- R6: Only codes with `adc_vld`=1 during a tread cycle are accumulated; codes presented in track or settle cycles are ignored.
- R7: In the track cycle after the last tread, `res_data` holds the sum of the accepted codes of that period. `res_vld` pulses for that one cycle when all N treads supplied a code. `res_data` keeps its value until the next result.
- R8: The sum starts from zero each period; earlier periods do not contribute.
- R9: If fewer than N codes were accepted in a period, `res_miss` pulses instead of `res_vld`; the two are never high together.
- R10: `res_data` is ADC_W+4 bits wide and holds 16 full-scale codes without overflow; the staircase reaches 15 times a full-scale step without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lg | input | 2 | Interpolation factor select, N = 2 << cfg_lg |
| cfg_step | input | 8 | Staircase step size |
| adc_vld | input | 1 | ADC code present this cycle |
| adc_code | input | 8 | Fast-ADC result |
| sh_hold | output | 1 | Sample-hold control, 1 = hold |
| stair_code | output | 12 | Interpolation DAC code |
| res_data | output | 12 | Accumulated sum (average with log2 N fraction bits) |
| res_vld | output | 1 | Complete result pulse |
| res_miss | output | 1 | Incomplete period pulse |

## Verification
Configuration is changed on every cycle while periods run. A design that samples it outside the track cycle would change the tread count or staircase slope in mid-period and break the period length. Codes are offered during track and settle cycles: an accumulator that accepts them would give sums that are too large. Back-to-back periods show whether the sum is cleared between samples. Gaps in `adc_vld` check that a short period raises the miss flag instead of a valid result. Full-scale codes and steps at N=16 expose any truncation of the sum or the staircase.

// File: rtl/di_pkg.sv
`timescale 1ns/1ps
package di_pkg;

  typedef enum logic [1:0] {
    PH_TRACK = 2'd0,
    PH_SETUP = 2'd1,
    PH_TREAD = 2'd2
  } phase_e;

  // number of treads for a factor select value
  function automatic int unsigned treads_of(input int unsigned lg);
    return 32'd2 << lg;
  endfunction

  // staircase level of tread k
  function automatic int unsigned stair_of(input int unsigned k, input int unsigned step);
    return k * step;
  endfunction

endpackage

// File: rtl/di_stair_seq.sv
`timescale 1ns/1ps
module di_stair_seq #(
  parameter int AMP_W   = 8,
  parameter int MAX_LG  = 4,
  parameter int LG_W    = 2,
  parameter int CNT_W   = MAX_LG + 1,
  parameter int STAIR_W = AMP_W + MAX_LG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LG_W-1:0]    cfg_lg,
  input  logic [AMP_W-1:0]   cfg_step,
  output logic               sh_hold,
  output logic [STAIR_W-1:0] stair,
  output logic               tread_en,
  output logic               tread_last,
  output logic               period_clr,
  output logic [CNT_W-1:0]   n_treads
);
  import di_pkg::*;

  localparam int K_W = MAX_LG;

  phase_e           ph_q;
  logic [K_W-1:0]   k_q;
  logic [LG_W-1:0]  lg_q;
  logic [AMP_W-1:0] step_q;

  assign n_treads   = CNT_W'(treads_of(32'(lg_q)));
  assign tread_en   = (ph_q == PH_TREAD);
  assign tread_last = tread_en && ((CNT_W'(k_q) + CNT_W'(1)) == n_treads);
  assign period_clr = (ph_q == PH_SETUP);
  assign sh_hold    = (ph_q != PH_TRACK);
  assign stair      = tread_en ? STAIR_W'(stair_of(32'(k_q), 32'(step_q))) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_TRACK;
      k_q    <= '0;
      lg_q   <= '0;
      step_q <= '0;
    end else begin
      case (ph_q)
        PH_TRACK: begin
          lg_q   <= cfg_lg;
          step_q <= cfg_step;
          k_q    <= '0;
          ph_q   <= PH_SETUP;
        end
        PH_SETUP: ph_q <= PH_TREAD;
        PH_TREAD: begin
          if (tread_last) ph_q <= PH_TRACK;
          else            k_q  <= k_q + K_W'(1);
        end
        default: ph_q <= PH_TRACK;
      endcase
    end
  end

  assert_settle_then_tread_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_clr |=> (tread_en && k_q == '0));
  assert_tread_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tread_en && !tread_last) |=> (tread_en && k_q == $past(k_q) + K_W'(1)));
  assert_tread_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tread_en |-> (CNT_W'(k_q) < n_treads));
  assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_TRACK) |=> ($stable(lg_q) && $stable(step_q)));

endmodule

// File: rtl/di_accum.sv
`timescale 1ns/1ps
module di_accum #(
  parameter int ADC_W = 8,
  parameter int CNT_W = 5,
  parameter int SUM_W = ADC_W + CNT_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tread_en,
  input  logic             tread_last,
  input  logic [CNT_W-1:0] n_treads,
  input  logic             adc_vld,
  input  logic [ADC_W-1:0] adc_code,
  output logic [SUM_W-1:0] res_data,
  output logic             res_vld,
  output logic             res_miss
);
  logic [SUM_W-1:0] sum_q, sum_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             take;
  logic             full;

  assign take    = tread_en && adc_vld;
  assign sum_nxt = sum_q + (take ? SUM_W'(adc_code) : '0);
  assign cnt_nxt = cnt_q + (take ? CNT_W'(1) : '0);
  assign full    = (cnt_nxt == n_treads);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q    <= '0;
      cnt_q    <= '0;
      res_data <= '0;
      res_vld  <= 1'b0;
      res_miss <= 1'b0;
    end else begin
      if (clr) begin
        sum_q <= '0;
        cnt_q <= '0;
      end else if (take) begin
        sum_q <= sum_nxt;
        cnt_q <= cnt_nxt;
      end
      res_vld  <= tread_last && full;
      res_miss <= tread_last && !full;
      if (tread_last) res_data <= sum_nxt;
    end
  end

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && sum_q == '0));
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tread_en |-> (cnt_q < n_treads));
  assert_result_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);

endmodule

// File: rtl/di_stair_avg.sv
`timescale 1ns/1ps
module di_stair_avg #(
  parameter int ADC_W  = 8,
  parameter int AMP_W  = 8,
  parameter int MAX_LG = 4,
  localparam int LG_W    = $clog2(MAX_LG),
  localparam int CNT_W   = MAX_LG + 1,
  localparam int STAIR_W = AMP_W + MAX_LG,
  localparam int RES_W   = ADC_W + MAX_LG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LG_W-1:0]    cfg_lg,
  input  logic [AMP_W-1:0]   cfg_step,
  input  logic               adc_vld,
  input  logic [ADC_W-1:0]   adc_code,
  output logic               sh_hold,
  output logic [STAIR_W-1:0] stair_code,
  output logic [RES_W-1:0]   res_data,
  output logic               res_vld,
  output logic               res_miss
);
  logic             tread_en;
  logic             tread_last;
  logic             period_clr;
  logic [CNT_W-1:0] n_treads;

  di_stair_seq #(
    .AMP_W(AMP_W), .MAX_LG(MAX_LG), .LG_W(LG_W), .CNT_W(CNT_W), .STAIR_W(STAIR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_lg(cfg_lg), .cfg_step(cfg_step),
    .sh_hold(sh_hold), .stair(stair_code), .tread_en(tread_en),
    .tread_last(tread_last), .period_clr(period_clr), .n_treads(n_treads)
  );

  di_accum #(
    .ADC_W(ADC_W), .CNT_W(CNT_W), .SUM_W(RES_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(period_clr), .tread_en(tread_en),
    .tread_last(tread_last), .n_treads(n_treads), .adc_vld(adc_vld),
    .adc_code(adc_code), .res_data(res_data), .res_vld(res_vld), .res_miss(res_miss)
  );

  assert_result_in_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld || res_miss) |-> (!sh_hold && stair_code == '0));
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_vld && res_miss));
  assert_hold_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_hold) |=> sh_hold);

endmodule

// File: tb/test_di_stair_avg.sv
`timescale 1ns/1ps
module test_di_stair_avg;
  localparam int ADC_W = 8, AMP_W = 8, LG_W = 2, STAIR_W = 12, RES_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LG_W-1:0]    cfg_lg = '0;
  logic [AMP_W-1:0]   cfg_step = '0;
  logic               adc_vld = 1'b0;
  logic [ADC_W-1:0]   adc_code = '0;
  logic               sh_hold;
  logic [STAIR_W-1:0] stair_code;
  logic [RES_W-1:0]   res_data;
  logic               res_vld;
  logic               res_miss;

  always #2.5 clk = ~clk;

  di_stair_avg i_di_stair_avg (
    .clk(clk), .rst_n(rst_n), .cfg_lg(cfg_lg), .cfg_step(cfg_step),
    .adc_vld(adc_vld), .adc_code(adc_code), .sh_hold(sh_hold),
    .stair_code(stair_code), .res_data(res_data), .res_vld(res_vld), .res_miss(res_miss)
  );

  int checks = 0, fails = 0;
  // reference state: position in period (0 track, 1 settle, 2+k tread k)
  int pos = 0, n_cur = 2, step_cur = 0;
  int got[$];
  int e_res = 0, e_vld = 0, e_miss = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2", "sh_hold", int'(sh_hold), (pos != 0) ? 1 : 0);
    chk("R3", "stair_code", int'(stair_code), (pos >= 2) ? (pos - 2) * step_cur : 0);
    chk("R7", "res_vld", int'(res_vld), e_vld);
    chk("R9", "res_miss", int'(res_miss), e_miss);
    chk("R7", "res_data", int'(res_data), e_res);
  endtask

  // advance reference by one clock edge using the inputs now applied
  task automatic advance();
    int s;
    e_vld = 0;
    e_miss = 0;
    if (pos == 0) begin
      n_cur = 2 << int'(cfg_lg);   // R4
      step_cur = int'(cfg_step);   // R5
      pos = 1;
    end else if (pos == 1) begin
      got.delete();                // R8
      pos = 2;
    end else begin
      if (adc_vld) got.push_back(int'(adc_code));  // R6
      if (pos - 2 == n_cur - 1) begin
        s = 0;
        foreach (got[i]) s += got[i];
        e_res = s;
        if (got.size() == n_cur) e_vld = 1; else e_miss = 1;
        pos = 0;
      end else begin
        pos++;
      end
    end
  endtask

  // scen: 0 random codes, 1 full scale, 2 churn config
  task automatic run(input int cycles, input int lg, input int stp, input int pct, input int scen);
    for (int c = 0; c < cycles; c++) begin
      if (scen == 2) begin
        cfg_lg = LG_W'($urandom_range(3));
        cfg_step = AMP_W'($urandom_range(255));
      end else begin
        cfg_lg = LG_W'(lg);
        cfg_step = AMP_W'(stp);
      end
      adc_vld = ($urandom_range(99) < pct);
      adc_code = (scen == 1) ? 8'hFF : ADC_W'($urandom_range(255));
      advance();
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL R2 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    adc_vld = 1'b1;
    adc_code = 8'hAA;
    cfg_lg = 2'd3;
    cfg_step = 8'd9;
    repeat (3) @(negedge clk);
    // R1: reset state with active inputs
    chk("R1", "sh_hold", int'(sh_hold), 0);
    chk("R1", "stair_code", int'(stair_code), 0);
    chk("R1", "res_vld", int'(res_vld), 0);
    chk("R1", "res_miss", int'(res_miss), 0);
    chk("R1", "res_data", int'(res_data), 0);
    rst_n = 1'b1;
    run(40, 0, 3, 100, 0);    // R4 N=2, R6 codes offered outside treads, R8 back to back
    run(60, 1, 7, 100, 0);    // R4 N=4
    run(90, 3, 255, 100, 1);  // R10 full scale N=16
    run(80, 2, 11, 70, 0);    // R9 gaps, N=8
    run(200, 0, 0, 100, 2);   // R5 config churn every cycle
    run(400, 0, 0, 90, 2);    // mixed
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule